// File: doc/BRIEF.md
# CAN Receive Mailbox with Status Life Cycle

This block is a single receive mailbox for a CAN controller. It holds one accepted frame in four 32-bit words and keeps a 4-bit status code with four states: inactive, empty, full and overrun. The frame arrives on a move-in port after acceptance matching has already chosen this mailbox. The port carries the identifier, the frame-type flags, the length, the timestamp and eight data bytes.

A CPU word port reads and writes the four words. Reading the control/status word (word 0) locks the mailbox. While it is locked, the move-in port reports busy and nothing is stored. Only an explicit unlock pulse releases the lock. A read followed by an unlock counts as the CPU servicing the mailbox.

The code does not return to empty when the CPU services the mailbox. Instead, whether the CPU serviced the mailbox before the next frame arrived decides whether that frame leaves the code full or marks it overrun. The CPU configures the mailbox by writing the code field.

Top module: `can_rx_mailbox`

## Requirements
- R1: The code field uses 4'b0000 for inactive, 4'b0100 for empty, 4'b0010 for full and 4'b0110 for overrun, and it never holds any other value. After reset the code is 4'b0000, all four words read zero and `mi_busy` is low.
- R2: While the code is inactive, a move-in request is ignored. The code stays 4'b0000 and no word changes.
- R3: A frame stored into an empty mailbox sets the code to full.
- R4: If the CPU reads word 0 and then pulses unlock while the code is full, the code stays full. The next stored frame also leaves it full.
- R5: A frame stored into a full mailbox that has not been serviced since the last store sets the code to overrun.
- R6: In the overrun state, a read of word 0 followed by an unlock makes the next stored frame return the code to full. Without that service, every further frame overwrites the data and the code stays overrun.
- R7: Word 0 carries the code in bits 27:24, SRR in bit 22, IDE in bit 21, RTR in bit 20, the length in bits 19:16 and the timestamp in bits 15:0. All other bits read zero.
- R8: Word 1 carries a CPU-written priority in bits 31:29, which a store does not change. An extended-format frame (IDE=1) puts its 29-bit identifier in bits 28:0. A standard frame puts its 11-bit identifier in bits 28:18, with bits 17:0 zero.
- R9: Word 2 holds data bytes 0 to 3 and word 3 holds bytes 4 to 7, with the lower-numbered byte in the more significant position. On `mi_data`, byte 0 is bits 63:56.
- R10: A CPU read of word 0 locks the mailbox. While locked, `mi_busy` is high and a move-in changes no word. Only an unlock pulse clears the lock.
- R11: The serviced state is cleared by every stored frame. After a read, an unlock and one store, a second store sets overrun.
- R12: A CPU write of empty or inactive to the code field clears both the lock and the serviced state. A CPU code write in the same cycle as a move-in takes priority: `mi_busy` is high that cycle, the frame is not stored, and the written code is kept.
- R13: A CPU write to word 0 whose code field is not one of the four legal values leaves the code unchanged but still updates the other word 0 fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mi_valid | input | 1 | Move-in request for one accepted frame |
| mi_id | input | 29 | Identifier; a standard frame uses bits 10:0 |
| mi_ide | input | 1 | Extended-format flag |
| mi_rtr | input | 1 | Remote-request flag |
| mi_srr | input | 1 | Substitute remote-request flag |
| mi_len | input | 4 | Data length code |
| mi_stamp | input | 16 | Timestamp |
| mi_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| mi_busy | output | 1 | Mailbox cannot take a frame this cycle |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Word select 0..3 |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data of the selected word, same cycle |
| cpu_unlock | input | 1 | Unlock pulse |

## Verification
Some rules are checked by assertions on every cycle. These cover the legality of the code, that an inactive mailbox never stores, and that a lock forces busy and persists until it is released. They also cover the code step taken on each store from empty, from full with or without service, and from a serviced state, plus the priority of a CPU code write over a move-in. The bench scenarios are needed for the rest. Only they can show the field positions and byte order seen from the CPU side, and the multi-frame histories where the read-and-unlock order decides between full and overrun. They also show that a locked or inactive mailbox really leaves the stored data untouched, and how an illegal code write is handled.

// File: rtl/can_rxmb_pkg.sv
package can_rxmb_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int ID_W      = 29;
  localparam int STD_ID_W  = 11;
  localparam int LEN_W     = 4;
  localparam int STAMP_W   = 16;
  localparam int NBYTES    = 8;
  localparam int DATA_W    = NBYTES * 8;
  localparam int DATA_WORDS = DATA_W / WORD_W;
  localparam int CODE_W    = 4;

  // bit positions inside word 0 and word 1
  localparam int CODE_LSB  = 24;
  localparam int SRR_POS   = 22;
  localparam int IDE_POS   = 21;
  localparam int RTR_POS   = 20;
  localparam int LEN_LSB   = 16;
  localparam int PRIO_LSB  = 29;
  localparam int PRIO_W    = WORD_W - PRIO_LSB;
  localparam int STD_PAD_W = ID_W - STD_ID_W;
  localparam int HDR_W     = 3 + LEN_W + STAMP_W;

  typedef enum logic [CODE_W-1:0] {
    MB_INACTIVE = 4'b0000,
    MB_EMPTY    = 4'b0100,
    MB_FULL     = 4'b0010,
    MB_OVERRUN  = 4'b0110
  } mb_code_e;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic               ide;
    logic               rtr;
    logic               srr;
    logic [LEN_W-1:0]   len;
    logic [STAMP_W-1:0] stamp;
    logic [DATA_W-1:0]  data;
  } mb_frame_t;

  function automatic logic code_is_legal(input logic [CODE_W-1:0] c);
    return (c == MB_INACTIVE) || (c == MB_EMPTY) ||
           (c == MB_FULL)     || (c == MB_OVERRUN);
  endfunction

endpackage

// File: rtl/can_rxmb_status.sv
module can_rxmb_status
  import can_rxmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_i,
  input  logic              csr_rd_i,
  input  logic              unlock_i,
  input  logic              code_wr_i,
  input  logic [CODE_W-1:0] code_wval_i,
  output mb_code_e          code_o,
  output logic              lock_o,
  output logic              srv_o
);

  mb_code_e code_q, code_d;
  logic     lock_q, lock_d;
  logic     srv_q, srv_d;
  logic     upd_en;

  assign upd_en = store_i | csr_rd_i | unlock_i | code_wr_i;

  always_comb begin
    code_d = code_q;
    lock_d = lock_q;
    srv_d  = srv_q;
    // lock and service tracking
    if (csr_rd_i) begin
      lock_d = 1'b1;
    end else if (unlock_i && lock_q) begin
      lock_d = 1'b0;
      srv_d  = 1'b1;
    end
    // automatic code step on an accepted frame
    if (store_i) begin
      srv_d = 1'b0;
      case (code_q)
        MB_EMPTY:   code_d = MB_FULL;
        MB_FULL,
        MB_OVERRUN: code_d = srv_q ? MB_FULL : MB_OVERRUN;
        default:    code_d = code_q;
      endcase
    end
    // CPU configuration wins over everything above
    if (code_wr_i) begin
      code_d = mb_code_e'(code_wval_i);
      if ((code_wval_i == MB_EMPTY) || (code_wval_i == MB_INACTIVE)) begin
        lock_d = 1'b0;
        srv_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MB_INACTIVE;
      lock_q <= 1'b0;
      srv_q  <= 1'b0;
    end else if (upd_en) begin
      code_q <= code_d;
      lock_q <= lock_d;
      srv_q  <= srv_d;
    end
  end

  assign code_o = code_q;
  assign lock_o = lock_q;
  assign srv_o  = srv_q;

endmodule

// File: rtl/can_rxmb_words.sv
module can_rxmb_words
  import can_rxmb_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  store_i,
  input  mb_frame_t                             frame_i,
  input  logic [NUM_WORDS-1:0]                  cpu_we_i,
  input  logic [WORD_W-1:0]                     cpu_wdata_i,
  input  mb_code_e                              code_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]      words_o
);

  // word 0 body: srr, ide, rtr, len, stamp
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic              hdr_en;
  logic [WORD_W-1:0] idw_q, idw_d;
  logic              idw_en;
  logic [ID_W-1:0]   id_field;

  // header
  always_comb begin
    hdr_d = hdr_q;
    if (cpu_we_i[0]) begin
      hdr_d = {cpu_wdata_i[SRR_POS], cpu_wdata_i[IDE_POS], cpu_wdata_i[RTR_POS],
               cpu_wdata_i[LEN_LSB +: LEN_W], cpu_wdata_i[STAMP_W-1:0]};
    end else if (store_i) begin
      hdr_d = {frame_i.srr, frame_i.ide, frame_i.rtr, frame_i.len, frame_i.stamp};
    end
  end
  assign hdr_en = cpu_we_i[0] | store_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdr_q <= '0;
    else if (hdr_en) hdr_q <= hdr_d;
  end

  // identifier word; priority is only written by the CPU
  assign id_field = frame_i.ide ? frame_i.id
                                : {frame_i.id[STD_ID_W-1:0], {STD_PAD_W{1'b0}}};

  always_comb begin
    idw_d = idw_q;
    if (cpu_we_i[1])  idw_d = cpu_wdata_i;
    else if (store_i) idw_d = {idw_q[WORD_W-1 -: PRIO_W], id_field};
  end
  assign idw_en = cpu_we_i[1] | store_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idw_q <= '0;
    else if (idw_en) idw_q <= idw_d;
  end

  assign words_o[0] = {4'b0000, code_i, 1'b0, hdr_q};
  assign words_o[1] = idw_q;

  // payload words, lower byte index in the upper bits
  for (genvar k = 0; k < DATA_WORDS; k++) begin : g_data
    logic [WORD_W-1:0] dw_q, dw_d;
    logic              dw_en;

    always_comb begin
      dw_d = dw_q;
      if (cpu_we_i[2+k]) dw_d = cpu_wdata_i;
      else if (store_i)  dw_d = frame_i.data[DATA_W-1-WORD_W*k -: WORD_W];
    end
    assign dw_en = cpu_we_i[2+k] | store_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dw_q <= '0;
      else if (dw_en) dw_q <= dw_d;
    end

    assign words_o[2+k] = dw_q;
  end

endmodule

// File: rtl/can_rxmb_rdmux.sv
module can_rxmb_rdmux
  import can_rxmb_pkg::*;
(
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  output logic [WORD_W-1:0]                rdata_o
);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = words_i[i];
    end
  end

endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
  import can_rxmb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mi_valid,
  input  logic [ID_W-1:0]       mi_id,
  input  logic                  mi_ide,
  input  logic                  mi_rtr,
  input  logic                  mi_srr,
  input  logic [LEN_W-1:0]      mi_len,
  input  logic [STAMP_W-1:0]    mi_stamp,
  input  logic [DATA_W-1:0]     mi_data,
  output logic                  mi_busy,
  input  logic                  cpu_sel,
  input  logic                  cpu_wr,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [WORD_W-1:0]     cpu_wdata,
  output logic [WORD_W-1:0]     cpu_rdata,
  input  logic                  cpu_unlock
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mb_code_e                         st_code;
  logic                             st_lock;
  logic                             st_srv;
  logic                             csr_rd;
  logic                             code_wr;
  logic [CODE_W-1:0]                code_wval;
  logic                             do_store;
  logic [NUM_WORDS-1:0]             cpu_we;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  mb_frame_t                        frame;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_we
    assign cpu_we[w] = cpu_sel & cpu_wr & (cpu_addr == ADDR_W'(w));
  end

  assign csr_rd    = cpu_sel & ~cpu_wr & (cpu_addr == '0);
  assign code_wval = cpu_wdata[CODE_LSB +: CODE_W];
  assign code_wr   = cpu_we[0] & code_is_legal(code_wval);
  assign mi_busy   = st_lock | code_wr;
  assign do_store  = mi_valid & ~mi_busy & (st_code != MB_INACTIVE);

  assign frame = '{id: mi_id, ide: mi_ide, rtr: mi_rtr, srr: mi_srr,
                   len: mi_len, stamp: mi_stamp, data: mi_data};

  can_rxmb_status u_status (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .store_i     (do_store),
    .csr_rd_i    (csr_rd),
    .unlock_i    (cpu_unlock),
    .code_wr_i   (code_wr),
    .code_wval_i (code_wval),
    .code_o      (st_code),
    .lock_o      (st_lock),
    .srv_o       (st_srv)
  );

  can_rxmb_words u_words (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .store_i     (do_store),
    .frame_i     (frame),
    .cpu_we_i    (cpu_we),
    .cpu_wdata_i (cpu_wdata),
    .code_i      (st_code),
    .words_o     (words)
  );

  can_rxmb_rdmux u_rdmux (
    .addr_i  (cpu_addr),
    .words_i (words),
    .rdata_o (cpu_rdata)
  );

endmodule

// File: rtl/can_rxmb_chk.sv
module can_rxmb_chk
  import can_rxmb_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input mb_code_e          st_code,
  input logic              st_lock,
  input logic              st_srv,
  input logic              do_store,
  input logic              mi_busy,
  input logic              cpu_unlock,
  input logic              code_wr,
  input logic [CODE_W-1:0] code_wval
);

  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n_s)
    code_is_legal(st_code));

  a_r2_inactive_no_store: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_code == MB_INACTIVE) |-> !do_store);

  a_r3_empty_fills: assert property (@(posedge clk) disable iff (!rst_n_s)
    (do_store && st_code == MB_EMPTY && !code_wr) |=> (st_code == MB_FULL));

  a_r4_serviced_full: assert property (@(posedge clk) disable iff (!rst_n_s)
    (do_store && st_srv && st_code != MB_EMPTY && !code_wr) |=> (st_code == MB_FULL));

  a_r5_full_overruns: assert property (@(posedge clk) disable iff (!rst_n_s)
    (do_store && st_code == MB_FULL && !st_srv && !code_wr) |=> (st_code == MB_OVERRUN));

  a_r6_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n_s)
    (do_store && st_code == MB_OVERRUN && !st_srv && !code_wr) |=> (st_code == MB_OVERRUN));

  a_r10_locked_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    st_lock |-> (mi_busy && !do_store));

  a_r10_lock_persists: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_lock && !cpu_unlock && !code_wr) |=> st_lock);

  a_r11_store_clears_srv: assert property (@(posedge clk) disable iff (!rst_n_s)
    do_store |=> !st_srv);

  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    code_wr |=> (st_code == $past(code_wval)));

  a_r12_write_blocks_store: assert property (@(posedge clk) disable iff (!rst_n_s)
    code_wr |-> !do_store);

endmodule

bind can_rx_mailbox can_rxmb_chk u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .st_code    (st_code),
  .st_lock    (st_lock),
  .st_srv     (st_srv),
  .do_store   (do_store),
  .mi_busy    (mi_busy),
  .cpu_unlock (cpu_unlock),
  .code_wr    (code_wr),
  .code_wval  (code_wval)
);

// File: tb/can_rx_mailbox_test.sv
module can_rx_mailbox_test;
  import can_rxmb_pkg::*;

  logic                clk;
  logic                rst_n;
  logic                mi_valid;
  logic [ID_W-1:0]     mi_id;
  logic                mi_ide, mi_rtr, mi_srr;
  logic [LEN_W-1:0]    mi_len;
  logic [STAMP_W-1:0]  mi_stamp;
  logic [DATA_W-1:0]   mi_data;
  logic                mi_busy;
  logic                cpu_sel, cpu_wr, cpu_unlock;
  logic [ADDR_W-1:0]   cpu_addr;
  logic [WORD_W-1:0]   cpu_wdata, cpu_rdata;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  can_rx_mailbox uut (
    .clk(clk), .rst_n(rst_n), .mi_valid(mi_valid), .mi_id(mi_id),
    .mi_ide(mi_ide), .mi_rtr(mi_rtr), .mi_srr(mi_srr), .mi_len(mi_len),
    .mi_stamp(mi_stamp), .mi_data(mi_data), .mi_busy(mi_busy),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_unlock(cpu_unlock)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // vector: {op[17:16], seed[15:8], expected code[7:4], requirement[3:0]}
  localparam logic [1:0] OP_STORE = 2'd0, OP_READ = 2'd1, OP_UNLK = 2'd2, OP_CODE = 2'd3;
  localparam int NV = 24;
  localparam logic [17:0] VEC [NV] = '{
    {OP_CODE,  8'd0,  4'b0100, 4'd12},  // configure empty
    {OP_STORE, 8'd10, 4'b0000, 4'd3},
    {OP_READ,  8'd10, 4'b0010, 4'd3},   // R3 empty -> full
    {OP_UNLK,  8'd0,  4'b0000, 4'd4},
    {OP_STORE, 8'd11, 4'b0000, 4'd4},
    {OP_READ,  8'd11, 4'b0010, 4'd4},   // R4 serviced full stays full
    {OP_UNLK,  8'd0,  4'b0000, 4'd11},
    {OP_STORE, 8'd12, 4'b0000, 4'd11},
    {OP_STORE, 8'd13, 4'b0000, 4'd5},
    {OP_READ,  8'd13, 4'b0110, 4'd5},   // R5 / R11 second store overruns
    {OP_UNLK,  8'd0,  4'b0000, 4'd6},
    {OP_STORE, 8'd14, 4'b0000, 4'd6},
    {OP_STORE, 8'd15, 4'b0000, 4'd6},
    {OP_STORE, 8'd16, 4'b0000, 4'd6},
    {OP_STORE, 8'd17, 4'b0000, 4'd6},
    {OP_READ,  8'd17, 4'b0110, 4'd6},   // R6 stays overrun, data overwritten
    {OP_UNLK,  8'd0,  4'b0000, 4'd6},
    {OP_STORE, 8'd18, 4'b0000, 4'd6},
    {OP_READ,  8'd18, 4'b0010, 4'd6},   // R6 serviced overrun -> full
    {OP_UNLK,  8'd0,  4'b0000, 4'd6},
    {OP_CODE,  8'd0,  4'b0000, 4'd2},
    {OP_STORE, 8'd19, 4'b0000, 4'd2},
    {OP_READ,  8'd18, 4'b0000, 4'd2},   // R2 inactive ignores move-in
    {OP_UNLK,  8'd0,  4'b0000, 4'd2}
  };

  function automatic mb_frame_t frame_of(input logic [7:0] s);
    mb_frame_t f;
    f.id    = {s, s, s, s[4:0]};
    f.ide   = s[0];
    f.rtr   = s[1];
    f.srr   = s[2];
    f.len   = s[3:0];
    f.stamp = {s, ~s};
    f.data  = {s, s + 8'd1, s + 8'd2, s + 8'd3, s + 8'd4, s + 8'd5, s + 8'd6, s + 8'd7};
    return f;
  endfunction

  function automatic logic [31:0] w2_of(input logic [7:0] s);
    return {s, s + 8'd1, s + 8'd2, s + 8'd3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    mi_valid = 0; cpu_sel = 0; cpu_wr = 0; cpu_unlock = 0;
    cpu_addr = '0; cpu_wdata = '0;
  endtask

  task automatic do_store(input mb_frame_t f, output logic busy);
    @(negedge clk);
    mi_valid = 1; mi_id = f.id; mi_ide = f.ide; mi_rtr = f.rtr; mi_srr = f.srr;
    mi_len = f.len; mi_stamp = f.stamp; mi_data = f.data;
    #5 busy = mi_busy;
    @(posedge clk); #1 idle();
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
    #5 d = cpu_rdata;
    @(posedge clk); #1 idle();
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1 idle();
  endtask

  task automatic unlock();
    @(negedge clk);
    cpu_unlock = 1;
    @(posedge clk); #1 idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        busy;
    mb_frame_t   f;
    idle();
    mi_id = '0; mi_ide = 0; mi_rtr = 0; mi_srr = 0; mi_len = '0; mi_stamp = '0; mi_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #5 check("R1 busy after reset", {31'b0, mi_busy}, 32'h0);
    for (int a = 1; a < 4; a++) begin
      cpu_read(2'(a), rd);
      check("R1 word after reset", rd, 32'h0);
    end
    cpu_read(2'd0, rd);
    check("R1 word0 after reset", rd, 32'h0);
    unlock();

    // vector table: life cycle of the code
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] sd;
      logic [3:0] ex;
      string      tag;
      op  = VEC[i][17:16];
      sd  = VEC[i][15:8];
      ex  = VEC[i][7:4];
      tag = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
      case (op)
        OP_STORE: begin
          do_store(frame_of(sd), busy);
          check({tag, " busy"}, {31'b0, busy}, 32'h0);
        end
        OP_READ: begin
          cpu_read(2'd2, rd);
          check({tag, " data"}, rd, w2_of(sd));
          cpu_read(2'd0, rd);
          check({tag, " code"}, {28'b0, rd[27:24]}, {28'b0, ex});
        end
        OP_UNLK: unlock();
        default: cpu_write(2'd0, {4'b0, ex, 24'b0});
      endcase
    end

    // R8 priority written by CPU, then extended frame layout (R7 R9)
    cpu_write(2'd1, 32'hA000_0000);
    cpu_write(2'd0, 32'h0400_0000);
    f.id = 29'h1ABC_DE12; f.ide = 1; f.rtr = 0; f.srr = 1; f.len = 4'd8;
    f.stamp = 16'hBEEF; f.data = 64'h0011_2233_4455_6677;
    do_store(f, busy);
    cpu_read(2'd1, rd);  check("R8 extended id with priority", rd, 32'hBABC_DE12);
    cpu_read(2'd2, rd);  check("R9 word2 byte order", rd, 32'h0011_2233);
    cpu_read(2'd3, rd);  check("R9 word3 byte order", rd, 32'h4455_6677);
    cpu_read(2'd0, rd);  check("R7 word0 layout", rd, 32'h0268_BEEF);

    // R10 locked mailbox refuses frames
    f.data = 64'hFFFF_FFFF_FFFF_FFFF;
    do_store(f, busy);
    check("R10 busy while locked", {31'b0, busy}, 32'h1);
    cpu_read(2'd2, rd);  check("R10 word2 untouched while locked", rd, 32'h0011_2233);
    unlock();
    #5 check("R10 busy cleared by unlock", {31'b0, mi_busy}, 32'h0);

    // R8 standard frame after service: code stays full (R4)
    f.id = 29'h0000_05A3; f.ide = 0; f.data = 64'hCAFE_F00D_1234_5678;
    do_store(f, busy);
    cpu_read(2'd1, rd);  check("R8 standard id placement", rd, 32'hB68C_0000);
    cpu_read(2'd0, rd);  check("R4 serviced store stays full", {28'b0, rd[27:24]}, 32'h2);

    // R12 code write clears lock and beats a same-cycle move-in
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = 2'd0; cpu_wdata = 32'h0400_0000;
    mi_valid = 1; mi_data = 64'h1111_2222_3333_4444;
    #5 check("R12 busy during code write", {31'b0, mi_busy}, 32'h1);
    @(posedge clk); #1 idle();
    #5 check("R12 lock cleared by empty write", {31'b0, mi_busy}, 32'h0);
    cpu_read(2'd2, rd);  check("R12 frame not stored", rd, 32'hCAFE_F00D);
    cpu_read(2'd0, rd);  check("R12 written code kept", rd, 32'h0400_0000);
    unlock();
    f.data = 64'h1111_2222_3333_4444;
    do_store(f, busy);
    cpu_read(2'd0, rd);  check("R12 empty after write then store full", {28'b0, rd[27:24]}, 32'h2);
    unlock();

    // R13 illegal code value ignored, other fields written
    cpu_write(2'd0, 32'h0F00_1234);
    cpu_read(2'd0, rd);  check("R13 illegal code ignored", rd, 32'h0200_1234);
    unlock();

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule